// File: doc/BRIEF.md
# Trigger-Level Byte FIFO with DMA Requests

This block is a byte-wide first-in first-out buffer meant to sit between a serial port's shifter and the on-chip bus, on either the receive or the transmit side. The producer writes with a push strobe and the consumer reads with a pop strobe. The block reports how full it is through two request lines for a DMA engine and an interrupt flag. A build-time direction parameter selects which meaning those request lines carry.

With buffering enabled, all sixteen entries are in use. A 3-bit select picks a trigger threshold as a fraction of the depth. On the receive side the burst request and the interrupt rise once enough data has piled up. On the transmit side they rise once the buffer has drained far enough. The single request marks the smallest useful transfer: on the receive side there is a byte to take, and on the transmit side there is a free slot to fill.

With buffering disabled, the storage shrinks to one entry. It then behaves as a classic holding register in front of the shifter, which gives double buffering. Any change of the enable flushes the stored data.

Top module: `dma_trig_fifo`

## Requirements
- R1: With `fifo_en`=1 the buffer holds 16 bytes and returns them in push order. `full` rises after the 16th push, and `empty` is high only when no byte is held.
- R2: With `fifo_en`=0 the buffer holds at most one byte. `full` rises after one push, and a second push without a pop is dropped.
- R3: When `fifo_en` differs from its value in the previous cycle, the buffer is empty in the next cycle. A push or pop in that cycle is ignored and does not set `overrun`.
- R4: `trig_sel` code 0, 1, 2, 3 or 4 selects a threshold of 2, 4, 8, 12 or 14 entries (1/8, 1/4, 1/2, 3/4 or 7/8 of 16). Codes 5 to 7 act as code 4.
- R5: With DIR=receive (0), `dma_single` is high whenever at least one byte is held. `dma_burst` and `trig_irq` are high when the fill count is at or above the threshold. When buffering is disabled, the threshold is one entry.
- R6: With DIR=transmit (1), `dma_single` is high whenever the fill count is below the capacity (16, or 1 when disabled). `dma_burst` and `trig_irq` are high when the fill count is at or below the threshold. When buffering is disabled, the threshold is zero entries.
- R7: A push while full, without a same-cycle pop, is dropped and sets `overrun`. `overrun` stays high until reset.
- R8: A pop while empty leaves `pop_data` at its previous value and leaves the fill count unchanged.
- R9: `pop_data` is registered. It shows the head byte in the cycle after the pop strobe.
- R10: A push and a pop in the same cycle while full are both accepted, and the buffer stays full.
- R11: After synchronous reset the buffer is empty, `overrun`=0 and `pop_data`=0. The receive variant drives both requests low. The transmit variant drives both requests high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1: 16-entry buffer; 0: one-byte holding register |
| trig_sel | input | 3 | Trigger threshold select (codes per R4) |
| push | input | 1 | Write strobe |
| push_data | input | 8 | Byte to write |
| pop | input | 1 | Read strobe |
| pop_data | output | 8 | Byte read, valid the cycle after `pop` |
| full | output | 1 | Fill count equals current capacity |
| empty | output | 1 | No byte held |
| overrun | output | 1 | Sticky flag: a push was dropped |
| trig_irq | output | 1 | Threshold reached (direction-dependent) |
| dma_single | output | 1 | Single-transfer request |
| dma_burst | output | 1 | Burst-transfer request |

## Verification
The hardest condition to reach from the ports is a push and a pop arriving together while every slot is occupied. The pop frees a slot in the same cycle that the push needs it, so the design must accept both and must not raise the overrun flag. The bench fills the buffer with sixteen distinct bytes, then raises both strobes in one cycle. It checks that `full` stays high, that the oldest byte comes out, and that the new byte comes out last after draining.

A second hard case is a mode change with a push pending in the same cycle. The bench turns buffering off while it pushes and checks that the buffer is empty and the flag is clear. Both receive and transmit variants run side by side on the same stimulus, so each fill level is checked against both request meanings.

// File: rtl/fifo_trig_pkg.sv
package fifo_trig_pkg;

    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } dir_e;

    typedef enum logic [2:0] {
        TRIG_EIGHTH  = 3'd0,
        TRIG_QUARTER = 3'd1,
        TRIG_HALF    = 3'd2,
        TRIG_3QTR    = 3'd3,
        TRIG_7EIGHTH = 3'd4
    } trig_sel_e;

    typedef struct packed {
        logic single;
        logic burst;
        logic irq;
    } dma_req_t;

    // Threshold numerator in eighths of the depth; out-of-range codes saturate.
    function automatic int unsigned trig_eighths(input logic [2:0] sel);
        case (trig_sel_e'(sel))
            TRIG_EIGHTH:  return 1;
            TRIG_QUARTER: return 2;
            TRIG_HALF:    return 4;
            TRIG_3QTR:    return 6;
            default:      return 7;
        endcase
    endfunction

endpackage

// File: rtl/fifo_trig_store.sv
module fifo_trig_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [CNT_W-1:0]  cap,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  count,
    output logic              overrun
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic              do_push, do_pop;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        do_pop  = pop && (count != '0) && !flush;
        do_push = push && !flush && ((count < cap) || do_pop);
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            rdata   <= '0;
            overrun <= 1'b0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_inc(wr_ptr);
            if (do_pop) begin
                rdata  <= mem[rd_ptr];
                rd_ptr <= ptr_inc(rd_ptr);
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: ;
            endcase
            if (push && !do_push) overrun <= 1'b1;
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH)); // R1

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun); // R7

    AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (count == cap && push && !pop && !flush) |=> $stable(count) && overrun); // R7

    AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && pop && !push && !flush) |=> $stable(rdata) && count == '0); // R8

endmodule

// File: rtl/fifo_trig_req.sv
module fifo_trig_req
    import fifo_trig_pkg::*;
#(
    parameter int   DEPTH = 16,
    parameter dir_e DIR   = DIR_RX,
    localparam int  CNT_W = $clog2(DEPTH) + 1
) (
    input  logic             fifo_en,
    input  logic [2:0]       trig_sel,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cap,
    output dma_req_t         req
);

    logic [CNT_W-1:0] thr;

    always_comb begin
        if (fifo_en)
            thr = CNT_W'((DEPTH * trig_eighths(trig_sel)) / 8);
        else
            thr = (DIR == DIR_TX) ? '0 : CNT_W'(1);
    end

    generate
        if (DIR == DIR_TX) begin : g_tx
            always_comb begin
                req.single = count < cap;
                req.burst  = count <= thr;
                req.irq    = count <= thr;
            end
        end else begin : g_rx
            always_comb begin
                req.single = count != '0;
                req.burst  = count >= thr;
                req.irq    = count >= thr;
            end
        end
    endgenerate

endmodule

// File: rtl/dma_trig_fifo.sv
module dma_trig_fifo
    import fifo_trig_pkg::*;
#(
    parameter int   DATA_W = 8,
    parameter int   DEPTH  = 16,
    parameter dir_e DIR    = DIR_RX,
    localparam int  CNT_W  = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_en,
    input  logic [2:0]        trig_sel,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic              full,
    output logic              empty,
    output logic              overrun,
    output logic              trig_irq,
    output logic              dma_single,
    output logic              dma_burst
);

    logic             en_q;
    logic             flush;
    logic [CNT_W-1:0] cap;
    logic [CNT_W-1:0] count;
    dma_req_t         req;

    always_ff @(posedge clk) begin
        en_q <= fifo_en;
    end

    always_comb begin
        flush = !rst && (fifo_en != en_q);
        cap   = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
        full  = count == cap;
        empty = count == '0;
    end

    fifo_trig_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .cap     (cap),
        .push    (push),
        .wdata   (push_data),
        .pop     (pop),
        .rdata   (pop_data),
        .count   (count),
        .overrun (overrun)
    );

    fifo_trig_req #(
        .DEPTH (DEPTH),
        .DIR   (DIR)
    ) u_req (
        .fifo_en  (fifo_en),
        .trig_sel (trig_sel),
        .count    (count),
        .cap      (cap),
        .req      (req)
    );

    assign dma_single = req.single;
    assign dma_burst  = req.burst;
    assign trig_irq   = req.irq;

    AST_HOLD_ONE: assert property (@(posedge clk) disable iff (rst)
        (!fifo_en && !en_q) |-> count <= CNT_W'(1)); // R2

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty && !$rose(overrun)); // R3

    AST_RX_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (DIR == DIR_RX) |-> (dma_single == !empty)); // R5

    AST_TX_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (DIR == DIR_TX && !flush) |-> (dma_single == !full)); // R6

endmodule

// File: tb/dma_trig_fifo_bench.sv
`timescale 1ns/1ps
module dma_trig_fifo_bench;
    import fifo_trig_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fifo_en = 1'b1;
    logic [2:0] trig_sel = 3'd0;
    logic       push = 1'b0;
    logic [7:0] push_data = 8'h00;
    logic       pop = 1'b0;

    logic [7:0] r_data, t_data;
    logic r_full, r_empty, r_ovr, r_irq, r_single, r_burst;
    logic t_full, t_empty, t_ovr, t_irq, t_single, t_burst;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    dma_trig_fifo #(.DIR(DIR_RX)) u_dma_trig_fifo (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .trig_sel(trig_sel),
        .push(push), .push_data(push_data), .pop(pop), .pop_data(r_data),
        .full(r_full), .empty(r_empty), .overrun(r_ovr), .trig_irq(r_irq),
        .dma_single(r_single), .dma_burst(r_burst)
    );

    dma_trig_fifo #(.DIR(DIR_TX)) u_dma_trig_fifo_tx (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .trig_sel(trig_sel),
        .push(push), .push_data(push_data), .pop(pop), .pop_data(t_data),
        .full(t_full), .empty(t_empty), .overrun(t_ovr), .trig_irq(t_irq),
        .dma_single(t_single), .dma_burst(t_burst)
    );

    // {trig_sel[2:0], fill[4:0], rx_burst, tx_burst}
    localparam int NVEC = 14;
    localparam logic [9:0] VEC [NVEC] = '{
        {3'd0, 5'd2,  1'b1, 1'b1},
        {3'd0, 5'd1,  1'b0, 1'b1},
        {3'd0, 5'd3,  1'b1, 1'b0},
        {3'd1, 5'd4,  1'b1, 1'b1},
        {3'd1, 5'd5,  1'b1, 1'b0},
        {3'd1, 5'd3,  1'b0, 1'b1},
        {3'd2, 5'd8,  1'b1, 1'b1},
        {3'd2, 5'd7,  1'b0, 1'b1},
        {3'd3, 5'd12, 1'b1, 1'b1},
        {3'd3, 5'd11, 1'b0, 1'b1},
        {3'd3, 5'd13, 1'b1, 1'b0},
        {3'd4, 5'd14, 1'b1, 1'b1},
        {3'd4, 5'd15, 1'b1, 1'b0},
        {3'd7, 5'd13, 1'b0, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; fifo_en = 1'b1; trig_sel = 3'd0; push = 1'b0; pop = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic push_byte(input logic [7:0] d);
        push = 1'b1; push_data = d;
        @(negedge clk);
        push = 1'b0;
    endtask

    task automatic pop_byte();
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    initial begin
        #1_000_000;
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R11 reset state
        chk("R11 rx empty", r_empty, 1);
        chk("R11 overrun", r_ovr, 0);
        chk("R11 pop_data", r_data, 0);
        chk("R11 rx single", r_single, 0);
        chk("R11 rx burst", r_burst, 0);
        chk("R11 tx single", t_single, 1);
        chk("R11 tx burst", t_burst, 1);

        // R4 R5 R6 threshold table
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            trig_sel = VEC[v][9:7];
            for (int i = 0; i < int'(VEC[v][6:2]); i++) push_byte(8'(i));
            chk("R4/R5 rx burst", r_burst, VEC[v][1]);
            chk("R5 rx irq", r_irq, VEC[v][1]);
            chk("R5 rx single", r_single, 1);
            chk("R4/R6 tx burst", t_burst, VEC[v][0]);
            chk("R6 tx irq", t_irq, VEC[v][0]);
            chk("R6 tx single", t_single, 1);
        end

        // R1 ordering, R7 overrun, R9 registered read, R8 empty pop
        do_reset();
        for (int i = 0; i < 16; i++) begin
            chk("R1 not full early", r_full, 0);
            push_byte(8'hA0 + 8'(i));
        end
        chk("R1 full", r_full, 1);
        chk("R6 tx single full", t_single, 0);
        chk("R7 no overrun yet", r_ovr, 0);
        push_byte(8'hEE);
        chk("R7 overrun set", r_ovr, 1);
        chk("R7 still full", r_full, 1);
        pop = 1'b1;
        #1;
        chk("R9 data before edge", r_data, 0);
        @(negedge clk);
        pop = 1'b0;
        chk("R9 R1 first byte", r_data, 8'hA0);
        for (int i = 1; i < 16; i++) begin
            pop_byte();
            chk("R1 order", r_data, 8'hA0 + 8'(i));
        end
        chk("R1 empty", r_empty, 1);
        pop_byte();
        chk("R8 pop_data held", r_data, 8'hAF);
        chk("R8 still empty", r_empty, 1);
        chk("R7 overrun sticky", r_ovr, 1);

        // R10 push and pop together while full
        do_reset();
        for (int i = 0; i < 16; i++) push_byte(8'h30 + 8'(i));
        push = 1'b1; push_data = 8'h55; pop = 1'b1;
        @(negedge clk);
        push = 1'b0; pop = 1'b0;
        chk("R10 still full", r_full, 1);
        chk("R10 head out", r_data, 8'h30);
        chk("R10 no overrun", r_ovr, 0);
        for (int i = 0; i < 16; i++) pop_byte();
        chk("R10 new byte last", r_data, 8'h55);
        chk("R10 drained", r_empty, 1);

        // R2 holding register mode
        do_reset();
        fifo_en = 1'b0;
        @(negedge clk);
        push_byte(8'h11);
        chk("R2 full at one", r_full, 1);
        chk("R5 rx burst hold", r_burst, 1);
        chk("R6 tx single hold", t_single, 0);
        chk("R6 tx burst hold", t_burst, 0);
        push_byte(8'h22);
        chk("R2 second dropped", r_ovr, 1);
        pop_byte();
        chk("R2 first byte kept", r_data, 8'h11);
        chk("R2 empty after pop", r_empty, 1);
        chk("R6 tx burst empty", t_burst, 1);
        chk("R5 rx single empty", r_single, 0);

        // R3 flush on mode change, push in that cycle ignored
        do_reset();
        for (int i = 0; i < 3; i++) push_byte(8'h70 + 8'(i));
        fifo_en = 1'b0;
        push_byte(8'h99);
        chk("R3 flushed", r_empty, 1);
        chk("R3 no overrun", r_ovr, 0);
        fifo_en = 1'b1;
        @(negedge clk);
        chk("R3 flushed on enable", r_empty, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule